// File: doc/BRIEF.md
# Prioritized Event Controller with Privilege Mode Tracking

This block sequences the events of a small processor core. It holds one request latch per priority level, gates the general levels through a mask register, and chooses the most urgent eligible request each cycle. Accepted events are recorded in an in-service register. The privilege mode presented to the rest of the core is taken from that record, so the core stays privileged for as long as any handler, even the lowest-priority one, is still open.

Level 0 is the emulation event and level 1 is the reset event. Levels 2 through `NUM_LEVELS-1` are general levels, fed by hardware request lines or by a software-raise command. The highest general level is the least urgent. Software can run its application privileged by raising the lowest level, returning out of reset, and entering the lowest handler without ever returning from it. A return strobe closes the most urgent open handler. A save strobe tells the block that the handler has stored its return address, and only then may a general event nest on top of it.

Top module: `event_sequencer`

## Requirements
- R1: While `rst_n` is low, `pend`, `ipend` and `mask` read zero and `mode` reads 0 (reset mode).
- R2: At the first rising clock edge after `rst_n` goes high, `ipend` becomes exactly bit 1 (reset event in service) and `mode` becomes 1 (supervisor).
- R3: `emu_req` sets `pend` bit 0. `irq_req[i]` sets `pend` bit i+2. A raise command with `raise_level` of 2 or more sets `pend` bit `raise_level`, and a raise with a level below 2 changes nothing. A pending bit clears at the edge that accepts its event.
- R4: A general level k is eligible only while `mask` bit k-2 is set. `mask` loads `mask_wdata` at an edge where `mask_we` is high. Emulation (level 0) cannot be masked.
- R5: Among eligible levels, the lowest index is chosen. It is accepted only if its index is strictly lower than the lowest set bit of `ipend`. So while the reset event is in service, only emulation is accepted and every general request stays pending.
- R6: An acceptance makes `accept` high for exactly one cycle, with `vector` holding the accepted level. It follows the edge at which the request became eligible by one edge, and the same edge sets that level's `ipend` bit.
- R7: While any `ipend` bit is set, a general level is accepted only when nesting is enabled. Every acceptance disables nesting. A `reti_saved` pulse or a return re-enables it. Emulation is accepted whatever the nesting state.
- R8: A `rti` pulse clears the lowest set bit of `ipend`, and no event is accepted at that edge. When `ipend` is zero, `rti` has no effect.
- R9: Outside the reset mode, `mode` is 1 (supervisor) whenever any `ipend` bit is set and 2 (user) when all are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset event line |
| emu_req | input | 1 | Emulation event request |
| irq_req | input | NUM_LEVELS-2 | General requests; bit i requests level i+2 |
| raise_valid | input | 1 | Software-raise command strobe |
| raise_level | input | clog2(NUM_LEVELS) | Level named by the raise command |
| rti | input | 1 | Return-from-event strobe |
| reti_saved | input | 1 | Return address stored; enables nesting |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | NUM_LEVELS-2 | Mask value; bit i enables level i+2 |
| mode | output | 2 | 0 reset, 1 supervisor, 2 user |
| accept | output | 1 | One-cycle acceptance pulse |
| vector | output | clog2(NUM_LEVELS) | Level being accepted |
| pend | output | NUM_LEVELS | Pending latches |
| mask | output | NUM_LEVELS-2 | Mask register |
| ipend | output | NUM_LEVELS | In-service register |

## Verification
The bench sweeps every general level through both request paths, first masked and then unmasked. A design with a mask-to-level offset error would accept the wrong level or accept nothing at all. Several scenarios check reset-only pre-emption and strict priority. A general request raised under the reset event, or a less urgent level raised under an open handler, must stay pending: a design using "lower or equal" priority, or one that forgets the reset level, would accept it early. The nesting scenario holds an urgent request back until the save strobe, and it checks that emulation still pre-empts with nesting disabled. The return tests check that a return closes only the lowest open bit and is harmless on an empty record. They also check that the mode falls to user only when the last in-service bit clears.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        MODE_RESET = 2'd0,
        MODE_SUPER = 2'd1,
        MODE_USER  = 2'd2
    } mode_t;

    localparam int EMU_LVL  = 0;
    localparam int RST_LVL  = 1;
    localparam int GEN_BASE = 2;

endpackage

// File: rtl/evc_first_set.sv
module evc_first_set #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/evc_req_capture.sv
module evc_req_capture
    import evc_pkg::*;
#(
    parameter int NUM_LEVELS = 16,
    parameter int LW         = 4
) (
    input  logic                  emu_req,
    input  logic [NUM_LEVELS-3:0] irq_req,
    input  logic                  raise_valid,
    input  logic [LW-1:0]         raise_level,
    output logic [NUM_LEVELS-1:0] set_vec
);

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        if (g == EMU_LVL) begin : g_emu
            assign set_vec[g] = emu_req;
        end else if (g == RST_LVL) begin : g_rst
            assign set_vec[g] = 1'b0;
        end else begin : g_gen
            assign set_vec[g] = irq_req[g-GEN_BASE]
                              | (raise_valid && (raise_level == LW'(g)));
        end
    end

endmodule

// File: rtl/event_sequencer.sv
module event_sequencer
    import evc_pkg::*;
#(
    parameter int NUM_LEVELS = 16,
    localparam int LW        = $clog2(NUM_LEVELS),
    localparam int NG        = NUM_LEVELS - GEN_BASE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  emu_req,
    input  logic [NG-1:0]         irq_req,
    input  logic                  raise_valid,
    input  logic [LW-1:0]         raise_level,
    input  logic                  rti,
    input  logic                  reti_saved,
    input  logic                  mask_we,
    input  logic [NG-1:0]         mask_wdata,
    output logic [1:0]            mode,
    output logic                  accept,
    output logic [LW-1:0]         vector,
    output logic [NUM_LEVELS-1:0] pend,
    output logic [NG-1:0]         mask,
    output logic [NUM_LEVELS-1:0] ipend
);

    typedef struct packed {
        logic                  boot;
        logic                  nest_en;
        logic [NUM_LEVELS-1:0] pend;
        logic [NG-1:0]         mask;
        logic [NUM_LEVELS-1:0] isr;
        logic                  accept;
        logic [LW-1:0]         vec;
    } state_t;

    localparam state_t RESET_STATE = '{
        boot: 1'b1, nest_en: 1'b0, pend: '0, mask: '0,
        isr: '0, accept: 1'b0, vec: '0
    };

    state_t s_d, s_q;

    logic [NUM_LEVELS-1:0] set_vec;
    logic [NUM_LEVELS-1:0] elig;
    logic                  cand_v, top_v, take;
    logic [LW-1:0]         cand, top;
    logic [NUM_LEVELS-1:0] cand_oh, top_oh;

    evc_req_capture #(.NUM_LEVELS(NUM_LEVELS), .LW(LW)) u_cap (
        .emu_req     (emu_req),
        .irq_req     (irq_req),
        .raise_valid (raise_valid),
        .raise_level (raise_level),
        .set_vec     (set_vec)
    );

    // General levels need their mask bit; the reset level never latches.
    assign elig = {s_q.pend[NUM_LEVELS-1:GEN_BASE] & s_q.mask,
                   1'b0, s_q.pend[EMU_LVL]};

    evc_first_set #(.W(NUM_LEVELS), .IW(LW)) u_cand (
        .vec   (elig),
        .found (cand_v),
        .idx   (cand)
    );

    evc_first_set #(.W(NUM_LEVELS), .IW(LW)) u_top (
        .vec   (s_q.isr),
        .found (top_v),
        .idx   (top)
    );

    assign cand_oh = NUM_LEVELS'(1) << cand;
    assign top_oh  = NUM_LEVELS'(1) << top;

    // Strictly more urgent than the open handler, and nesting gate for general levels.
    assign take = !s_q.boot && !rti && cand_v
               && (!top_v || (cand < top))
               && ((cand == LW'(EMU_LVL)) || !top_v || s_q.nest_en);

    always_comb begin
        s_d        = s_q;
        s_d.accept = 1'b0;
        s_d.pend   = s_q.pend | set_vec;

        if (mask_we) begin
            s_d.mask = mask_wdata;
        end

        if (s_q.boot) begin
            s_d.boot           = 1'b0;
            s_d.isr            = '0;
            s_d.isr[RST_LVL]   = 1'b1;
            s_d.nest_en        = 1'b0;
        end else if (rti) begin
            if (top_v) begin
                s_d.isr = s_q.isr & ~top_oh;
            end
            s_d.nest_en = 1'b1;
        end else begin
            if (reti_saved) begin
                s_d.nest_en = 1'b1;
            end
            if (take) begin
                s_d.pend    = (s_q.pend & ~cand_oh) | set_vec;
                s_d.isr     = s_q.isr | cand_oh;
                s_d.accept  = 1'b1;
                s_d.vec     = cand;
                s_d.nest_en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RESET_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (s_q.boot) begin
            mode = MODE_RESET;
        end else if (|s_q.isr) begin
            mode = MODE_SUPER;
        end else begin
            mode = MODE_USER;
        end
    end

    assign accept = s_q.accept;
    assign vector = s_q.vec;
    assign pend   = s_q.pend;
    assign mask   = s_q.mask;
    assign ipend  = s_q.isr;

endmodule

// File: rtl/event_sequencer_chk.sv
module event_sequencer_chk
    import evc_pkg::*;
#(
    parameter int NUM_LEVELS = 16,
    localparam int LW        = $clog2(NUM_LEVELS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rti,
    input logic [1:0]            mode,
    input logic                  accept,
    input logic [LW-1:0]         vector,
    input logic [NUM_LEVELS-1:0] ipend
);

    // R6: an accepted level is recorded in service at the same edge
    p_accept_in_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ipend[vector]);

    // R5: nothing more urgent than the accepted level is open
    p_strict_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ((ipend & ((NUM_LEVELS'(1) << vector) - NUM_LEVELS'(1))) == '0));

    // R8: a return on a non-empty record closes exactly one handler
    p_return_clears_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && (ipend != '0)) |=> ($countones(ipend) == $past($countones(ipend)) - 1));

    // R8: no acceptance at a return edge
    p_no_accept_on_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rti |=> !accept);

    // R2: leaving reset mode opens exactly the reset level in supervisor mode
    p_boot_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RESET) |=> ((ipend == (NUM_LEVELS'(1) << RST_LVL)) && (mode == MODE_SUPER)));

    // R9: user mode only with an empty record
    p_user_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_USER) |-> (ipend == '0));

endmodule

bind event_sequencer event_sequencer_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rti    (rti),
    .mode   (mode),
    .accept (accept),
    .vector (vector),
    .ipend  (ipend)
);

// File: tb/event_sequencer_tb.sv
module event_sequencer_tb;

    localparam int NL = 16;
    localparam int LW = 4;
    localparam int NG = NL - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          emu_req = 1'b0;
    logic [NG-1:0] irq_req = '0;
    logic          raise_valid = 1'b0;
    logic [LW-1:0] raise_level = '0;
    logic          rti = 1'b0;
    logic          reti_saved = 1'b0;
    logic          mask_we = 1'b0;
    logic [NG-1:0] mask_wdata = '0;
    logic [1:0]    mode;
    logic          accept;
    logic [LW-1:0] vector;
    logic [NL-1:0] pend;
    logic [NG-1:0] mask;
    logic [NL-1:0] ipend;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    event_sequencer #(.NUM_LEVELS(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .emu_req(emu_req), .irq_req(irq_req),
        .raise_valid(raise_valid), .raise_level(raise_level), .rti(rti),
        .reti_saved(reti_saved), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .mode(mode), .accept(accept), .vector(vector), .pend(pend),
        .mask(mask), .ipend(ipend)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_raise(int lvl);
        raise_valid = 1'b1;
        raise_level = LW'(lvl);
        step();
        raise_valid = 1'b0;
    endtask

    task automatic do_rti();
        rti = 1'b1;
        step();
        rti = 1'b0;
    endtask

    task automatic do_save();
        reti_saved = 1'b1;
        step();
        reti_saved = 1'b0;
    endtask

    task automatic write_mask(logic [NG-1:0] v);
        mask_we = 1'b1;
        mask_wdata = v;
        step();
        mask_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [NG-1:0] multi;
        int first;
        repeat (3) step();
        chk("R1", "mode", 32'(mode), 0);
        chk("R1", "pend", 32'(pend), 0);
        chk("R1", "ipend", 32'(ipend), 0);
        chk("R1", "mask", 32'(mask), 0);

        rst_n = 1'b1;
        step();
        chk("R2", "mode", 32'(mode), 1);
        chk("R2", "ipend", 32'(ipend), 32'h2);

        // General request under the reset event must wait
        mask_we = 1'b1;
        mask_wdata = '1;
        do_raise(15);
        mask_we = 1'b0;
        step(); step();
        chk("R5", "accept under reset", 32'(accept), 0);
        chk("R5", "pend under reset", 32'(pend), 32'h8000);
        chk("R5", "ipend under reset", 32'(ipend), 32'h2);
        do_raise(1);
        step();
        chk("R3", "raise level 1 ignored", 32'(pend), 32'h8000);

        // Emulation pre-empts reset
        emu_req = 1'b1;
        step();
        emu_req = 1'b0;
        step();
        chk("R5", "emu accept", 32'(accept), 1);
        chk("R6", "emu vector", 32'(vector), 0);
        chk("R6", "emu ipend", 32'(ipend), 32'h3);
        chk("R3", "emu latch cleared", 32'(pend), 32'h8000);
        do_rti();
        chk("R8", "rti closes emu", 32'(ipend), 32'h2);
        chk("R8", "no accept at rti", 32'(accept), 0);

        // Leave reset, then lowest level enters
        do_rti();
        chk("R9", "user after last rti", 32'(mode), 2);
        chk("R9", "ipend empty", 32'(ipend), 0);
        step();
        chk("R6", "accept level 15", 32'(accept), 1);
        chk("R6", "vector 15", 32'(vector), 15);
        chk("R9", "supervisor in level 15", 32'(mode), 1);

        // Nesting gate
        do_raise(5);
        step(); step();
        chk("R7", "nest blocked accept", 32'(accept), 0);
        chk("R7", "nest blocked pend", 32'(pend), 32'h20);
        do_save();
        step();
        chk("R7", "accept after save", 32'(accept), 1);
        chk("R7", "vector 5", 32'(vector), 5);
        chk("R7", "ipend 5+15", 32'(ipend), 32'h8020);

        // Less urgent level waits under open level 5
        do_raise(10);
        do_save();
        step();
        chk("R5", "level 10 held", 32'(pend), 32'h400);
        chk("R5", "level 10 ipend", 32'(ipend), 32'h8020);
        do_rti();
        chk("R8", "rti closes 5", 32'(ipend), 32'h8000);
        step();
        chk("R5", "level 10 accepted", 32'(vector), 10);
        chk("R5", "ipend 10+15", 32'(ipend), 32'h8400);
        do_rti();
        chk("R8", "rti closes 10", 32'(ipend), 32'h8000);
        do_rti();
        chk("R9", "user again", 32'(mode), 2);
        do_rti();
        chk("R8", "rti on empty", 32'(ipend), 0);
        chk("R8", "mode unchanged", 32'(mode), 2);

        // Sweep every general level: masked, then unmasked
        for (int lvl = 2; lvl < NL; lvl++) begin
            write_mask('0);
            if (lvl % 2 == 0) begin
                irq_req[lvl-2] = 1'b1;
                step();
                irq_req = '0;
            end else begin
                do_raise(lvl);
            end
            step(); step();
            chk("R4", "masked no service", 32'(ipend), 0);
            chk("R4", "masked stays pending", 32'(pend), 32'(1) << lvl);
            write_mask(NG'(1) << (lvl - 2));
            chk("R4", "mask readback", 32'(mask), 32'(1) << (lvl - 2));
            step();
            chk("R6", "sweep accept", 32'(accept), 1);
            chk("R6", "sweep vector", 32'(vector), 32'(lvl));
            chk("R3", "sweep latch cleared", 32'(pend), 0);
            do_rti();
            chk("R8", "sweep return", 32'(ipend), 0);
        end

        // Simultaneous requests: levels 4, 9, 12 (irq bits 2, 7, 10)
        write_mask('1);
        multi = '0;
        multi[2] = 1'b1; multi[7] = 1'b1; multi[10] = 1'b1;
        irq_req = multi;
        step();
        irq_req = '0;
        first = NL;
        for (int i = NG - 1; i >= 0; i--) if (multi[i]) first = i + 2;
        step();
        chk("R5", "most urgent first", 32'(vector), 32'(first));
        chk("R6", "accept multi", 32'(accept), 1);
        step();
        chk("R5", "others wait", 32'(accept), 0);
        do_rti();
        step();
        chk("R5", "next is 9", 32'(vector), 9);
        do_rti();
        step();
        chk("R5", "next is 12", 32'(vector), 12);
        do_rti();
        chk("R9", "all closed", 32'(mode), 2);

        // Emulation ignores the nesting gate
        do_raise(7);
        step();
        chk("R6", "level 7 accepted", 32'(vector), 7);
        emu_req = 1'b1;
        step();
        emu_req = 1'b0;
        step();
        chk("R7", "emu with nest off", 32'(vector), 0);
        chk("R7", "emu ipend", 32'(ipend), 32'h81);

        // Reset mid-service
        rst_n = 1'b0;
        step();
        chk("R1", "mode in reset", 32'(mode), 0);
        chk("R1", "ipend cleared", 32'(ipend), 0);
        chk("R1", "pend cleared", 32'(pend), 0);
        chk("R1", "mask cleared", 32'(mask), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule